// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries a processor from the moment an interrupt is taken to the moment its program counter points at the handler. A hardware request is taken when the current instruction retires, or at once when a long repeating instruction is running and may be suspended. A software trap instruction starts the same sequence with its own vector number. The sequencer then runs a fixed 18-cycle schedule on a simple single-cycle memory bus. It reads the acknowledge word and clears the matching request. It keeps a hidden copy of the flags and masks the interrupt-enable, single-step and stack-select flags. It pushes the saved flags and the return address, sets the new priority level and fetches the handler address from the vector table.

The core holds its own architectural state and hands it over on `flags_in`, `pc_in`, `sp_in` and `ipl_in` when the sequence starts. It takes the updated values back from the output ports once `done` has been seen. Read data is expected in the same cycle as the read strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: A hardware request (`irq_pend`=1) is taken only in a cycle where `insn_end`=1 or `rpt_busy`=1. The sequence occupies the 18 cycles that follow, called c0 to c17, with `busy`=1 in each of them. Without either strobe the block stays idle.
- R2: With `rpt_busy`=1 a pending request is taken without `insn_end`, and the sequence is identical to one taken at a boundary.
- R3: For a hardware entry, c0 is a read of address 0. The returned word carries the vector number in bits [5:0] and the priority level in bits [10:8].
- R4: For a hardware entry, `clr_pulse` is high for exactly cycle c1, with `clr_num` equal to the acknowledged number. It is low in every other cycle.
- R5: From c2, `flags_out` equals the flags taken at entry with bit 6 (interrupt enable), bit 3 (single step) and bit 7 (stack select) cleared. All other bits are unchanged.
- R6: For a software entry with a number of 32 or more, bit 7 of `flags_out` keeps its entry value.
- R7: c4 writes address SP-2 with {PC[19:16], entry flags[11:0]}. c7 writes address SP-4 with PC[15:0]. From c8, `sp_out` equals SP-4.
- R8: From c9, `ipl_out` equals the level accepted for the entry.
- R9: c11 reads address VEC_BASE+4*number (default VEC_BASE=0xFFD00) to get PC[15:0]. c14 reads that address +2, whose bits [3:0] give PC[19:16]. `pc_out` holds the handler address in c17.
- R10: `done` is high only in c17, and `busy` falls in the cycle after. Every cycle other than c0, c4, c7, c11 and c14 has both strobes low. Read and write are never high together.
- R11: A software entry (`sw_req`=1) takes its number from `sw_num` and makes no bus access in c0. It raises no `clr_pulse` and leaves `ipl_out` at `ipl_in`.
- R12: Requests and boundary strobes that arrive during a sequence have no effect on its bus schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | 1 | An arbitrated hardware request is pending |
| insn_end | input | 1 | Current instruction completes this cycle |
| rpt_busy | input | 1 | A suspendable repeating instruction is running |
| sw_req | input | 1 | Software trap instruction requests entry |
| sw_num | input | 6 | Vector number of the software trap |
| flags_in | input | 12 | Flag register at entry |
| pc_in | input | 20 | Return address at entry |
| sp_in | input | 20 | Stack pointer at entry |
| ipl_in | input | 3 | Priority level at entry |
| bus_rdata | input | 16 | Read data, valid in the strobe cycle |
| bus_addr | output | 20 | Byte address, 0 when no access |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data |
| flags_out | output | 12 | Updated flag register |
| ipl_out | output | 3 | Updated priority level |
| pc_out | output | 20 | Updated program counter |
| sp_out | output | 20 | Updated stack pointer |
| clr_pulse | output | 1 | Clear request of the acknowledged source |
| clr_num | output | 6 | Number of the source to clear |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final cycle of the sequence |

## Verification
The bench builds the block with its default parameters: a 20-bit program counter on a 16-bit bus, a 6-bit vector number and the default vector base. The 20-bit counter makes the upper return-address nibble ride in the flag word, so a wrong split of the return address shows on the bus. The 6-bit number reaches traps on both sides of 32, so the stack-select rule is tested both ways. Vector numbers 5 and 40 land at different table offsets, which exposes a wrong vector address.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int STEP_W = 5;
  typedef logic [STEP_W-1:0] step_t;

  // Fixed schedule, one step per CPU clock
  localparam step_t ST_ACK     = 5'd0;
  localparam step_t ST_CLR     = 5'd1;
  localparam step_t ST_PUSH_HI = 5'd4;
  localparam step_t ST_PUSH_LO = 5'd7;
  localparam step_t ST_IPL     = 5'd8;
  localparam step_t ST_VEC_LO  = 5'd11;
  localparam step_t ST_VEC_HI  = 5'd14;
  localparam step_t ST_LOAD    = 5'd16;
  localparam step_t ST_LAST    = 5'd17;

  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} bus_op_e;
  typedef enum logic [2:0] {ADR_ZERO, ADR_SP2, ADR_SP4, ADR_VEC, ADR_VEC2} adr_sel_e;

  typedef struct packed {
    bus_op_e  op;
    adr_sel_e adr;
  } cyc_cmd_t;

  function automatic cyc_cmd_t step_cmd(step_t step, logic from_sw);
    cyc_cmd_t c;
    c = '{op: OP_IDLE, adr: ADR_ZERO};
    case (step)
      ST_ACK:     if (!from_sw) c = '{op: OP_READ, adr: ADR_ZERO};
      ST_PUSH_HI: c = '{op: OP_WRITE, adr: ADR_SP2};
      ST_PUSH_LO: c = '{op: OP_WRITE, adr: ADR_SP4};
      ST_VEC_LO:  c = '{op: OP_READ,  adr: ADR_VEC};
      ST_VEC_HI:  c = '{op: OP_READ,  adr: ADR_VEC2};
      default:    c = '{op: OP_IDLE,  adr: ADR_ZERO};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_entry_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  irq_pend,
  input  logic  insn_end,
  input  logic  rpt_busy,
  input  logic  sw_req,
  output logic  start,
  output logic  active,
  output step_t step,
  output logic  from_sw,
  output logic  last
);

  logic  active_d, from_sw_d;
  step_t step_d;
  logic  hw_take;

  assign hw_take = irq_pend & (insn_end | rpt_busy);
  assign start   = !active & (sw_req | hw_take);
  assign last    = active && (step == ST_LAST);

  always_comb begin
    active_d  = active;
    step_d    = step;
    from_sw_d = from_sw;
    if (start) begin
      active_d  = 1'b1;
      step_d    = '0;
      from_sw_d = sw_req;
    end else if (active) begin
      if (last) begin
        active_d = 1'b0;
        step_d   = '0;
      end else begin
        step_d = step + step_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      step    <= '0;
      from_sw <= 1'b0;
    end else begin
      active  <= active_d;
      step    <= step_d;
      from_sw <= from_sw_d;
    end
  end

  // R1: an accepted request begins the sequence at step 0 next cycle
  a_r1_start_next: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && step == ST_ACK));

  // R12: once running, steps advance by one regardless of new requests
  a_r12_steady_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> (active && step == $past(step) + step_t'(1)));

endmodule

// File: rtl/irq_seq_ctx.sv
module irq_seq_ctx
  import irq_entry_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int PCW         = 20,
  parameter int FW          = 12,
  parameter int NUMW        = 6,
  parameter int LVLW        = 3,
  parameter int IE_POS      = 6,
  parameter int STEP_POS    = 3,
  parameter int STK_POS     = 7,
  parameter int SW_KEEP_MIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sw_req,
  input  logic [NUMW-1:0] sw_num,
  input  logic            active,
  input  step_t           step,
  input  logic            from_sw,
  input  logic [FW-1:0]   flags_in,
  input  logic [PCW-1:0]  pc_in,
  input  logic [AW-1:0]   sp_in,
  input  logic [LVLW-1:0] ipl_in,
  input  logic [DW-1:0]   bus_rdata,
  output logic [FW-1:0]   tmp_q,
  output logic [FW-1:0]   flags_q,
  output logic [PCW-1:0]  pc_q,
  output logic [AW-1:0]   spb_q,
  output logic [AW-1:0]   sp_q,
  output logic [LVLW-1:0] ipl_q,
  output logic [NUMW-1:0] num_q
);

  localparam int HIW = PCW - DW;

  logic [FW-1:0]   tmp_d, flags_d;
  logic [PCW-1:0]  pc_d;
  logic [AW-1:0]   spb_d, sp_d;
  logic [LVLW-1:0] ipl_d, lvl_q, lvl_d;
  logic [NUMW-1:0] num_d;
  logic [DW-1:0]   vlo_q, vlo_d;
  logic [HIW-1:0]  vhi_q, vhi_d;
  logic            keep_stk;

  assign keep_stk = from_sw && (num_q >= NUMW'(SW_KEEP_MIN));

  always_comb begin
    tmp_d = tmp_q; flags_d = flags_q; pc_d = pc_q; spb_d = spb_q; sp_d = sp_q;
    ipl_d = ipl_q; lvl_d = lvl_q; num_d = num_q; vlo_d = vlo_q; vhi_d = vhi_q;
    if (start) begin
      tmp_d   = flags_in;
      flags_d = flags_in;
      pc_d    = pc_in;
      spb_d   = sp_in;
      sp_d    = sp_in;
      ipl_d   = ipl_in;
      lvl_d   = ipl_in;
      if (sw_req) num_d = sw_num;
    end else if (active) begin
      case (step)
        ST_ACK: if (!from_sw) begin
          num_d = bus_rdata[NUMW-1:0];
          lvl_d = bus_rdata[8 +: LVLW];
        end
        ST_CLR: begin
          flags_d[IE_POS]   = 1'b0;
          flags_d[STEP_POS] = 1'b0;
          if (!keep_stk) flags_d[STK_POS] = 1'b0;
        end
        ST_PUSH_LO: sp_d  = spb_q - AW'(4);
        ST_IPL:     ipl_d = lvl_q;
        ST_VEC_LO:  vlo_d = bus_rdata;
        ST_VEC_HI:  vhi_d = bus_rdata[HIW-1:0];
        ST_LOAD:    pc_d  = {vhi_q, vlo_q};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q <= '0; flags_q <= '0; pc_q <= '0; spb_q <= '0; sp_q <= '0;
      ipl_q <= '0; lvl_q <= '0; num_q <= '0; vlo_q <= '0; vhi_q <= '0;
    end else begin
      tmp_q <= tmp_d; flags_q <= flags_d; pc_q <= pc_d; spb_q <= spb_d; sp_q <= sp_d;
      ipl_q <= ipl_d; lvl_q <= lvl_d; num_q <= num_d; vlo_q <= vlo_d; vhi_q <= vhi_d;
    end
  end

  // R5: by the last step, enable and single-step are masked
  a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step == ST_LAST) |-> (!flags_q[IE_POS] && !flags_q[STEP_POS]));

  // R7: stack pointer drops by four after the second push
  a_r7_sp_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step == ST_IPL) |-> (sp_q == $past(sp_q) - AW'(4)));

  // R5: the hidden copy never changes during a sequence
  a_r5_tmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step != ST_ACK) |-> $stable(tmp_q));

endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
  import irq_entry_pkg::*;
#(
  parameter int              AW       = 20,
  parameter int              DW       = 16,
  parameter int              PCW      = 20,
  parameter int              FW       = 12,
  parameter int              NUMW     = 6,
  parameter logic [AW-1:0]   VEC_BASE = '0
) (
  input  logic            active,
  input  step_t           step,
  input  logic            from_sw,
  input  logic [AW-1:0]   spb,
  input  logic [NUMW-1:0] num,
  input  logic [PCW-1:0]  pc,
  input  logic [FW-1:0]   tmp,
  output logic [AW-1:0]   addr,
  output logic            rd,
  output logic            wr,
  output logic [DW-1:0]   wdata
);

  cyc_cmd_t      cmd;
  logic [AW-1:0] vec;

  assign cmd = step_cmd(step, from_sw);
  assign vec = VEC_BASE + AW'({num, 2'b00});

  always_comb begin
    rd    = active && (cmd.op == OP_READ);
    wr    = active && (cmd.op == OP_WRITE);
    addr  = '0;
    wdata = '0;
    if (active) begin
      case (cmd.adr)
        ADR_SP2:  begin addr = spb - AW'(2); wdata = {pc[PCW-1:DW], tmp}; end
        ADR_SP4:  begin addr = spb - AW'(4); wdata = pc[DW-1:0]; end
        ADR_VEC:  addr = vec;
        ADR_VEC2: addr = vec + AW'(2);
        default:  addr = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int            AW          = 20,
  parameter int            DW          = 16,
  parameter int            PCW         = 20,
  parameter int            NUMW        = 6,
  parameter int            LVLW        = 3,
  parameter int            IE_POS      = 6,
  parameter int            STEP_POS    = 3,
  parameter int            STK_POS     = 7,
  parameter int            SW_KEEP_MIN = 32,
  parameter logic [AW-1:0] VEC_BASE    = 20'hFFD00,
  parameter int            FW          = DW - (PCW - DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_pend,
  input  logic            insn_end,
  input  logic            rpt_busy,
  input  logic            sw_req,
  input  logic [NUMW-1:0] sw_num,
  input  logic [FW-1:0]   flags_in,
  input  logic [PCW-1:0]  pc_in,
  input  logic [AW-1:0]   sp_in,
  input  logic [LVLW-1:0] ipl_in,
  input  logic [DW-1:0]   bus_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic [DW-1:0]   bus_wdata,
  output logic [FW-1:0]   flags_out,
  output logic [LVLW-1:0] ipl_out,
  output logic [PCW-1:0]  pc_out,
  output logic [AW-1:0]   sp_out,
  output logic            clr_pulse,
  output logic [NUMW-1:0] clr_num,
  output logic            busy,
  output logic            done
);

  logic            start, active, from_sw, last;
  step_t           step;
  logic [FW-1:0]   tmp_q;
  logic [AW-1:0]   spb_q;
  logic [NUMW-1:0] num_q;

  irq_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .insn_end(insn_end),
    .rpt_busy(rpt_busy), .sw_req(sw_req), .start(start), .active(active),
    .step(step), .from_sw(from_sw), .last(last)
  );

  irq_seq_ctx #(
    .AW(AW), .DW(DW), .PCW(PCW), .FW(FW), .NUMW(NUMW), .LVLW(LVLW),
    .IE_POS(IE_POS), .STEP_POS(STEP_POS), .STK_POS(STK_POS), .SW_KEEP_MIN(SW_KEEP_MIN)
  ) u_ctx (
    .clk(clk), .rst_n(rst_n), .start(start), .sw_req(sw_req), .sw_num(sw_num),
    .active(active), .step(step), .from_sw(from_sw), .flags_in(flags_in),
    .pc_in(pc_in), .sp_in(sp_in), .ipl_in(ipl_in), .bus_rdata(bus_rdata),
    .tmp_q(tmp_q), .flags_q(flags_out), .pc_q(pc_out), .spb_q(spb_q),
    .sp_q(sp_out), .ipl_q(ipl_out), .num_q(num_q)
  );

  irq_seq_bus #(
    .AW(AW), .DW(DW), .PCW(PCW), .FW(FW), .NUMW(NUMW), .VEC_BASE(VEC_BASE)
  ) u_bus (
    .active(active), .step(step), .from_sw(from_sw), .spb(spb_q), .num(num_q),
    .pc(pc_out), .tmp(tmp_q), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata)
  );

  assign busy      = active;
  assign done      = last;
  assign clr_pulse = active && (step == ST_CLR) && !from_sw;
  assign clr_num   = num_q;

  // R10: strobes are exclusive
  a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R10: busy ends right after done
  a_r10_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R4: the clear request lasts one cycle
  a_r4_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);

  // R10: no bus activity while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_rd && !bus_wr));

endmodule

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;

  localparam logic [19:0] VBASE = 20'hFFD00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_pend, insn_end, rpt_busy, sw_req;
  logic [5:0]  sw_num;
  logic [11:0] flags_in;
  logic [19:0] pc_in, sp_in;
  logic [2:0]  ipl_in;
  logic [15:0] bus_rdata;
  logic [19:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata;
  logic [11:0] flags_out;
  logic [2:0]  ipl_out;
  logic [19:0] pc_out, sp_out;
  logic        clr_pulse;
  logic [5:0]  clr_num;
  logic        busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // memory model
  logic [15:0] ack_word, vec_lo, vec_hi;
  logic [19:0] vec_a;

  always #2.5 clk = ~clk;

  always_comb begin
    if (bus_addr == 20'h0)               bus_rdata = ack_word;
    else if (bus_addr == vec_a)          bus_rdata = vec_lo;
    else if (bus_addr == vec_a + 20'd2)  bus_rdata = vec_hi;
    else                                 bus_rdata = 16'hDEAD;
  end

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .insn_end(insn_end),
    .rpt_busy(rpt_busy), .sw_req(sw_req), .sw_num(sw_num), .flags_in(flags_in),
    .pc_in(pc_in), .sp_in(sp_in), .ipl_in(ipl_in), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .flags_out(flags_out), .ipl_out(ipl_out), .pc_out(pc_out), .sp_out(sp_out),
    .clr_pulse(clr_pulse), .clr_num(clr_num), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset();
    irq_pend = 0; insn_end = 0; rpt_busy = 0; sw_req = 0; sw_num = 0;
    flags_in = 0; pc_in = 0; sp_in = 0; ipl_in = 0;
    ack_word = 0; vec_lo = 0; vec_hi = 0; vec_a = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R10", "reset busy/done", {busy, done}, 0);
    chk(!bus_rd && !bus_wr, "R10", "reset strobes", {bus_rd, bus_wr}, 0);
    chk(!clr_pulse, "R4", "reset clr_pulse", clr_pulse, 0);
    chk(ipl_out == 0 && pc_out == 0, "R8", "reset ipl/pc", {ipl_out, pc_out}, 0);
  endtask

  // R1: pending without a boundary or repeat strobe is not taken
  task automatic t_no_boundary();
    irq_pend = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!busy && !bus_rd && !bus_wr, "R1", "no accept off boundary",
          {busy, bus_rd, bus_wr}, 0);
    end
    irq_pend = 0;
  endtask

  task automatic t_entry(input bit sw, input bit use_rpt, input logic [5:0] num,
                         input logic [2:0] lvl, input logic [11:0] flg,
                         input logic [19:0] pc, input logic [19:0] sp,
                         input logic [2:0] ipl0);
    logic [11:0] ef;
    logic [2:0]  el;
    logic [19:0] handler;
    bit          exp_rd, exp_wr;
    logic [19:0] exp_addr;
    logic [15:0] exp_wd;
    string       rq;
    rq = sw ? "R11" : (use_rpt ? "R2" : "R1");
    ef = flg; ef[6] = 0; ef[3] = 0;
    if (!(sw && num >= 6'd32)) ef[7] = 0;
    el = sw ? ipl0 : lvl;
    ack_word = {5'b0, lvl, 2'b0, num};
    vec_a    = VBASE + {12'b0, num, 2'b00};
    vec_lo   = pc[15:0] ^ 16'hA5C3;
    vec_hi   = {12'h0, pc[19:16] ^ 4'h9};
    handler  = {vec_hi[3:0], vec_lo};
    @(negedge clk);
    flags_in = flg; pc_in = pc; sp_in = sp; ipl_in = ipl0;
    if (sw) begin
      sw_req = 1; sw_num = num;
    end else begin
      irq_pend = 1;
      if (use_rpt) rpt_busy = 1; else insn_end = 1;
    end
    @(negedge clk);
    // now in c0; scramble inputs to show they are ignored (R12)
    sw_req = 0;
    flags_in = ~flg; pc_in = ~pc; sp_in = ~sp; ipl_in = ~ipl0;
    if (!sw) begin irq_pend = 1; insn_end = 1; end
    for (int k = 0; k < 18; k++) begin
      exp_rd = 0; exp_wr = 0; exp_addr = 0; exp_wd = 0;
      case (k)
        0:  begin exp_rd = !sw; exp_addr = 0; end
        4:  begin exp_wr = 1; exp_addr = sp - 20'd2; exp_wd = {pc[19:16], flg}; end
        7:  begin exp_wr = 1; exp_addr = sp - 20'd4; exp_wd = pc[15:0]; end
        11: begin exp_rd = 1; exp_addr = vec_a; end
        14: begin exp_rd = 1; exp_addr = vec_a + 20'd2; end
        default: ;
      endcase
      chk(busy, rq, $sformatf("busy c%0d", k), busy, 1);
      chk(bus_rd == exp_rd && bus_wr == exp_wr, (k == 0) ? "R3" : "R10",
          $sformatf("strobes c%0d", k), {bus_rd, bus_wr}, {exp_rd, exp_wr});
      if (exp_rd || exp_wr)
        chk(bus_addr == exp_addr, (k < 4) ? "R3" : ((k < 8) ? "R7" : "R9"),
            $sformatf("addr c%0d", k), bus_addr, exp_addr);
      if (exp_wr)
        chk(bus_wdata == exp_wd, "R7", $sformatf("wdata c%0d", k), bus_wdata, exp_wd);
      chk(clr_pulse == (k == 1 && !sw), sw ? "R11" : "R4",
          $sformatf("clr_pulse c%0d", k), clr_pulse, (k == 1 && !sw));
      if (k == 1 && !sw) chk(clr_num == num, "R4", "clr_num", clr_num, num);
      if (k == 2) chk(flags_out == ef, (sw && num >= 6'd32) ? "R6" : "R5",
                      "flags_out", flags_out, ef);
      if (k == 8) chk(sp_out == sp - 20'd4, "R7", "sp_out", sp_out, sp - 20'd4);
      if (k == 9) chk(ipl_out == el, sw ? "R11" : "R8", "ipl_out", ipl_out, el);
      chk(done == (k == 17), "R10", $sformatf("done c%0d", k), done, (k == 17));
      if (k == 17) begin
        chk(pc_out == handler, "R9", "pc_out handler", pc_out, handler);
        irq_pend = 0; insn_end = 0; rpt_busy = 0;
      end
      @(negedge clk);
    end
    chk(!busy && !done, "R10", "idle after done", {busy, done}, 0);
    chk(!bus_rd && !bus_wr, "R12", "no restart", {bus_rd, bus_wr}, 0);
  endtask

  initial begin
    rst_n = 0;
    t_reset();
    t_no_boundary();
    t_entry(0, 0, 6'd5,  3'd3, 12'hFC8, 20'h1_2345, 20'h0_0800, 3'd1);
    t_entry(0, 1, 6'd40, 3'd7, 12'h0C9, 20'hA_BCDE, 20'h0_4000, 3'd2);
    t_entry(1, 0, 6'd40, 3'd0, 12'h0C8, 20'h5_0F10, 20'h0_1000, 3'd4);
    t_entry(1, 0, 6'd10, 3'd0, 12'h0C8, 20'h3_3330, 20'h0_2002, 3'd5);
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

endmodule